// File: doc/BRIEF.md
# Bit-Serial Configurable Logic Cell

This block is one programmable logic cell of a fabric aimed at bit-serial arithmetic and bit-level pipelining. It holds four 4-input lookup tables, four output flip-flops and two dedicated shift flip-flops. Each table reads one of two 4-bit input groups, and its top address bit can be switched to a feedback line for carry-save loops. A feedback line is a constant, its own input pin, or the registered value of one of the cell's four outputs. Two neighbouring tables can be merged into a 5-input function by a select input. Each output is either combinational or registered. A table can also be reused as a 16-bit shift register.

All configuration sits in one serial chain that shifts on the data clock while `cfg_en` is high. The table contents are part of that chain. A synchronous reset clears the six data flip-flops and leaves the configuration alone.

Top module: `bsl_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts the 94-bit configuration word up by one and enters `cfg_in` at bit 0, so a word is sent MSB first. Field layout from MSB to LSB: table 3, 2, 1, 0 (16 bits each, table bit k at field bit k); feedback selects for lines 3..0 (3 bits each); group select [3:0]; shift-mode enable [3:0]; pair-merge enable [3:0]; register enable [3:0]; carry-save enable [1:0].
- R2: While `cfg_en` is low, the configuration does not change, whatever `cfg_in` does. The one exception is R9.
- R3: Table i outputs bit `{a_in[3:0]}` of its contents when group select i is 0, and bit `{b_in[3:0]}` when it is 1.
- R4: When carry-save enable p is 1, tables 2p and 2p+1 take address bit 3 from their own feedback lines instead of from the group input.
- R5: Feedback line i selects as follows. Code 1 gives 0 and code 2 gives 1. Codes 4 to 7 give the output flip-flop of output (code-4), whether or not that output is bypassed. Codes 0 and 3 give pin `c_in[i+2]`.
- R6: When pair-merge enable i is 1, mux i outputs table 2p+1 if its select is 1 and table 2p if it is 0. The select is `a_in[4]` for pair p=0 (tables 0 and 1) and `b_in[4]` for pair p=1 (tables 2 and 3). Otherwise mux i outputs table i.
- R7: With register enable i at 0, `d_out[i]` follows mux i in the same cycle. With it at 1, `d_out[i]` shows the mux i value from the previous rising edge.
- R8: `s_out[0]` and `s_out[1]` show `c_in[0]` and `c_in[1]` as sampled at the previous rising edge.
- R9: With shift-mode enable i at 1, `cfg_en` low and `x_in[0]` high, each edge shifts table i up by one, with `x_in[1]` entering bit 0. Reads still follow R3 and R4.
- R10: `rst` high at a rising edge clears all six data flip-flops to 0 and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for data, configuration and table shifting |
| rst | input | 1 | Synchronous active-high clear of the data flip-flops |
| cfg_en | input | 1 | Configuration chain shift enable |
| cfg_in | input | 1 | Configuration serial data |
| a_in | input | 5 | Group A address bits [3:0] and pair-0 merge select [4] |
| b_in | input | 5 | Group B address bits [3:0] and pair-1 merge select [4] |
| c_in | input | 6 | Shift flip-flop data [1:0] and feedback pins [5:2] |
| x_in | input | 2 | Table shift enable [0] and table serial data [1] |
| d_out | output | 4 | Cell outputs, combinational or registered |
| s_out | output | 2 | Shift flip-flop outputs |

## Verification
The bench loads both directed and random configurations through the chain, then compares every cycle against a model built from the requirements. Several corner cases are targeted. Feedback taken from a bypassed output must still read the flip-flop; a design that used the live mux would give same-cycle values. In merged pairs the select must not swap the even and odd tables; swapping inverts the selected half. Table shifting must not occur while `cfg_en` is high or the enable is low; otherwise the contents drift and later reads go wrong. Reset must not touch the tables, and a design that cleared them would output zeros after every reset.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
    localparam int NLUT   = 4;
    localparam int LUT_K  = 4;
    localparam int LUT_W  = 1 << LUT_K;
    localparam int FB_W   = 3;
    localparam int NPAIR  = NLUT / 2;
    localparam int NSHIFT = 2;

    typedef struct packed {
        logic [NLUT-1:0][LUT_W-1:0] lut;
        logic [NLUT-1:0][FB_W-1:0]  fb;
        logic [NLUT-1:0]            grp;
        logic [NLUT-1:0]            srm;
        logic [NLUT-1:0]            m5;
        logic [NLUT-1:0]            rgo;
        logic [NPAIR-1:0]           cs;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/bsl_cfg_chain.sv
module bsl_cfg_chain
    import bsl_pkg::*;
(
    input  logic      clk,
    input  logic      cfg_en,
    input  logic      cfg_in,
    input  logic      sh_en,
    input  logic      sh_din,
    output cell_cfg_t cfg
);
    cell_cfg_t        cfg_d, cfg_q;
    logic [CFG_W-1:0] flat_q;

    assign flat_q = cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_en) begin
            cfg_d = cell_cfg_t'({flat_q[CFG_W-2:0], cfg_in});
        end else if (sh_en) begin
            for (int i = 0; i < NLUT; i++) begin
                if (cfg_q.srm[i]) begin
                    cfg_d.lut[i] = {cfg_q.lut[i][LUT_W-2:0], sh_din};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bsl_fb_sel.sv
module bsl_fb_sel
    import bsl_pkg::*;
(
    input  logic [FB_W-1:0] sel,
    input  logic            pin,
    input  logic [NLUT-1:0] q,
    output logic            f
);
    always_comb begin
        if (sel[FB_W-1]) begin
            f = q[sel[FB_W-2:0]];
        end else begin
            case (sel[FB_W-2:0])
                2'd1:    f = 1'b0;
                2'd2:    f = 1'b1;
                default: f = pin;
            endcase
        end
    end
endmodule

// File: rtl/bsl_lut_read.sv
module bsl_lut_read #(
    parameter int K = 4,
    localparam int W = 1 << K
) (
    input  logic [W-1:0] tbl,
    input  logic [K-1:0] a_grp,
    input  logic [K-1:0] b_grp,
    input  logic         grp_sel,
    input  logic         cs_en,
    input  logic         fb_bit,
    output logic         y
);
    logic [K-1:0] addr;

    always_comb begin
        addr = grp_sel ? b_grp : a_grp;
        if (cs_en) begin
            addr[K-1] = fb_bit;
        end
        y = tbl[addr];
    end
endmodule

// File: rtl/bsl_cell.sv
module bsl_cell
    import bsl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_in,
    input  logic [4:0]   a_in,
    input  logic [4:0]   b_in,
    input  logic [5:0]   c_in,
    input  logic [1:0]   x_in,
    output logic [3:0]   d_out,
    output logic [1:0]   s_out
);
    typedef struct packed {
        logic [NLUT-1:0]   dq;
        logic [NSHIFT-1:0] sq;
    } cell_st_t;

    cell_st_t        st_d, st_q;
    cell_cfg_t       cfg;
    logic [NLUT-1:0] fbv, y, o;

    bsl_cfg_chain u_cfg (
        .clk    (clk),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .sh_en  (x_in[0]),
        .sh_din (x_in[1]),
        .cfg    (cfg)
    );

    for (genvar i = 0; i < NLUT; i++) begin : g_slice
        localparam int PAIR = i / 2;
        localparam int EVN  = PAIR * 2;
        localparam int ODD  = EVN + 1;
        logic ctl;

        bsl_fb_sel u_fb (
            .sel (cfg.fb[i]),
            .pin (c_in[i+2]),
            .q   (st_q.dq),
            .f   (fbv[i])
        );

        bsl_lut_read #(.K(LUT_K)) u_lut (
            .tbl     (cfg.lut[i]),
            .a_grp   (a_in[LUT_K-1:0]),
            .b_grp   (b_in[LUT_K-1:0]),
            .grp_sel (cfg.grp[i]),
            .cs_en   (cfg.cs[PAIR]),
            .fb_bit  (fbv[i]),
            .y       (y[i])
        );

        if (PAIR == 0) begin : g_sel_a
            assign ctl = a_in[4];
        end else begin : g_sel_b
            assign ctl = b_in[4];
        end

        assign o[i]     = cfg.m5[i] ? (ctl ? y[ODD] : y[EVN]) : y[i];
        assign d_out[i] = cfg.rgo[i] ? st_q.dq[i] : o[i];

        // R7: registered output shows last edge's mux value
        p_reg_out_r7: assert property (@(posedge clk) disable iff (rst)
            (cfg.rgo[i] && !cfg_en) |=> (d_out[i] == $past(o[i])));

        // R9: shift-mode table shifts serial data into bit 0
        p_lut_shift_r9: assert property (@(posedge clk) disable iff (rst)
            (!cfg_en && x_in[0] && cfg.srm[i]) |=>
            (cfg.lut[i][0] == $past(x_in[1]) &&
             cfg.lut[i][LUT_W-1:1] == $past(cfg.lut[i][LUT_W-2:0])));
    end

    always_comb begin
        st_d.dq = o;
        st_d.sq = c_in[NSHIFT-1:0];
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign s_out = st_q.sq;

    // R1: chain enters cfg_in at the lowest bit
    p_cfg_load_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg.cs[0] == $past(cfg_in)));

    // R2: configuration held when neither loading nor shifting
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !x_in[0]) |=> $stable(cfg));

    // R8: shift flip-flops capture c_in[1:0]
    p_shift_ff_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (s_out == $past(c_in[NSHIFT-1:0])));

    // R10: reset leaves every data flip-flop at zero
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q == '0));
endmodule

// File: tb/bsl_cell_tb.sv
module bsl_cell_tb;
    import bsl_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [4:0] a_in = '0;
    logic [4:0] b_in = '0;
    logic [5:0] c_in = '0;
    logic [1:0] x_in = '0;
    logic [3:0] d_out;
    logic [1:0] s_out;

    int    checks = 0;
    int    errors = 0;
    string tag = "R10";

    cell_cfg_t mcfg;
    logic [3:0] mq;
    logic [1:0] ms;
    bit cfg_known = 0;
    bit q_known = 0;

    bsl_cell u_dut (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .a_in   (a_in),
        .b_in   (b_in),
        .c_in   (c_in),
        .x_in   (x_in),
        .d_out  (d_out),
        .s_out  (s_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [3:0] ref_mux(cell_cfg_t cf, logic [4:0] a, logic [4:0] b,
                                           logic [5:0] c, logic [3:0] q);
        logic [3:0] yv, ov;
        for (int i = 0; i < 4; i++) begin
            logic [3:0] ad;
            logic       fl;
            case (cf.fb[i])
                3'd1:    fl = 1'b0;
                3'd2:    fl = 1'b1;
                3'd4:    fl = q[0];
                3'd5:    fl = q[1];
                3'd6:    fl = q[2];
                3'd7:    fl = q[3];
                default: fl = c[i+2];
            endcase
            ad = cf.grp[i] ? b[3:0] : a[3:0];
            if (cf.cs[i/2]) ad[3] = fl;
            yv[i] = cf.lut[i][ad];
        end
        for (int i = 0; i < 4; i++) begin
            logic s;
            s = (i < 2) ? a[4] : b[4];
            if (cf.m5[i]) ov[i] = s ? yv[(i & 2) + 1] : yv[i & 2];
            else          ov[i] = yv[i];
        end
        return ov;
    endfunction

    task automatic cyc(input logic r, input logic ce, input logic ci, input logic [4:0] a,
                       input logic [4:0] b, input logic [5:0] c, input logic [1:0] x);
        logic [3:0] eo, ed;
        @(negedge clk);
        rst = r; cfg_en = ce; cfg_in = ci;
        a_in = a; b_in = b; c_in = c; x_in = x;
        #1;
        eo = ref_mux(mcfg, a, b, c, mq);
        ed = (mcfg.rgo & mq) | (~mcfg.rgo & eo);
        if (cfg_known && q_known) begin
            checks++;
            if (d_out !== ed) begin
                errors++;
                $display("FAIL %s d_out actual=%b expected=%b", tag, d_out, ed);
            end
            checks++;
            if (s_out !== ms) begin
                errors++;
                $display("FAIL R8 s_out actual=%b expected=%b", s_out, ms);
            end
        end
        if (r) begin
            mq = '0; ms = '0; q_known = 1;
        end else begin
            mq = eo; ms = c[1:0];
        end
        if (ce) begin
            logic [CFG_W-1:0] v;
            v = mcfg;
            mcfg = cell_cfg_t'({v[CFG_W-2:0], ci});
            q_known = r;
        end else if (x[0]) begin
            for (int i = 0; i < 4; i++)
                if (mcfg.srm[i]) mcfg.lut[i] = {mcfg.lut[i][14:0], x[1]};
        end
    endtask

    task automatic rnd_cyc(input logic r);
        cyc(r, 1'b0, 1'($urandom), 5'($urandom), 5'($urandom), 6'($urandom), 2'($urandom));
    endtask

    task automatic load_cfg(input cell_cfg_t cf);
        logic [CFG_W-1:0] v;
        v = cf;
        cfg_known = 0;
        for (int k = CFG_W - 1; k >= 0; k--) begin
            cyc(1'b0, 1'b1, v[k], 5'($urandom), 5'($urandom), 6'($urandom), 2'($urandom));
        end
        cfg_known = 1;
        tag = "R10";
        rnd_cyc(1'b1);
        tag = "R1";
        rnd_cyc(1'b0);
    endtask

    task automatic run(input int n, input int rst_odds);
        for (int k = 0; k < n; k++) begin
            rnd_cyc(rst_odds > 0 && ($urandom % rst_odds) == 0);
        end
    endtask

    initial begin
        cell_cfg_t cf;
        void'($urandom(32'd2024));
        mcfg = '0; mq = '0; ms = '0;

        // R3: plain table reads, group A then group B
        cf = '0;
        cf.lut[0] = 16'hA5C3; cf.lut[1] = 16'h0FF0;
        cf.lut[2] = 16'h8001; cf.lut[3] = 16'h6996;
        load_cfg(cf);
        tag = "R3";
        for (int k = 0; k < 16; k++) cyc(1'b0, 1'b0, 1'b0, 5'(k), 5'($urandom), 6'($urandom), 2'b00);
        cf.grp = 4'b1111;
        load_cfg(cf);
        tag = "R3";
        for (int k = 0; k < 16; k++) cyc(1'b0, 1'b0, 1'b1, 5'($urandom), 5'(k), 6'($urandom), 2'b00);

        // R4 and R5: carry-save address bit from feedback lines
        cf.grp = 4'b0101; cf.cs = 2'b11;
        cf.fb[0] = 3'd1; cf.fb[1] = 3'd2; cf.fb[2] = 3'd0; cf.fb[3] = 3'd5;
        load_cfg(cf);
        tag = "R4";
        run(40, 0);
        cf.fb[0] = 3'd7; cf.fb[1] = 3'd4; cf.fb[2] = 3'd6; cf.fb[3] = 3'd3;
        cf.rgo = 4'b0011;
        load_cfg(cf);
        tag = "R5";
        run(40, 0);

        // R6: merged pairs
        cf.cs = 2'b00; cf.rgo = 4'b0000; cf.m5 = 4'b1111; cf.grp = 4'b0000;
        load_cfg(cf);
        tag = "R6";
        run(40, 0);

        // R7: registered outputs
        cf.m5 = 4'b0110; cf.rgo = 4'b1111;
        load_cfg(cf);
        tag = "R7";
        run(40, 0);

        // R10: resets mixed in, configuration must survive
        tag = "R10";
        run(40, 4);

        // R9: tables as shift registers
        cf.srm = 4'b1011; cf.rgo = 4'b0100; cf.m5 = 4'b0000;
        load_cfg(cf);
        tag = "R9";
        run(60, 0);

        // R2: cfg_in toggles with cfg_en low and no table shifting
        cf.srm = 4'b0000;
        load_cfg(cf);
        tag = "R2";
        for (int k = 0; k < 40; k++)
            cyc(1'b0, 1'b0, 1'(k), 5'($urandom), 5'($urandom), 6'($urandom), 2'b00);

        // random configurations
        for (int n = 0; n < 25; n++) begin
            logic [CFG_W-1:0] v;
            for (int k = 0; k < CFG_W; k++) v[k] = 1'($urandom);
            load_cfg(cell_cfg_t'(v));
            tag = "R5";
            run(40, 10);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule